// File: doc/BRIEF.md
# SD Card Data Path Controller

This block runs the data half of an SD/SDIO host over a single-bit DAT line. It moves data between the card and a pair of host-side FIFO ports, a write port for data from the card and a show-ahead read port for data to the card. Transfers are framed either as blocks or as streams. Each block carries a CRC16 trailer. After every block sent to the card, the card returns a CRC status token and may then hold the line low while it is busy.

A single write to the control port starts or stops the machine. That write carries an enable, a direction, a block/stream select, a block length in bytes, a total length in bits, and a timeout in card clocks. One clock cycle of `clk` is one card clock. Four sticky status flags report the outcome: timeout, CRC failure, FIFO error and data end. An enabling control write clears all four.

For SDIO, the block can also hold DAT low as a read-wait signal while it is idle. This needs the block to still be enabled and the host to request read-wait.

Top module: `sd_dpath`

## Requirements
- R1: After reset, and in the idle state, `dat_oe` is low, `rx_wr` is low and all four status flags are clear.
- R2: A control write with `cfg_en`=1 clears the flags and loads the counters. `cfg_dir`=1 selects card-to-host, so the block waits for a start bit (DAT low). `cfg_dir`=0 selects host-to-card, so the block sends once the transmit FIFO is not empty.
- R3: In block receive, bits arrive MSB first after the start bit. Every 8 bits produce one `rx_wr` pulse carrying that byte, and `cfg_blklen` bytes make one block.
- R4: While waiting for a start bit, if no start bit is seen within `cfg_timeout`+1 clocks of entering the wait, `st_timeout` is set and the block goes idle. The same timeout applies while waiting on the card after a sent block.
- R5: The 16 bits that follow a received block are checked against CRC16 (polynomial x^16+x^12+x^5+1, initial value 0, computed over the data bits in order). On a match the block waits for the next start bit. On a mismatch `st_crcfail` is set, the block goes idle, and later line activity writes nothing.
- R6: In stream receive there is no CRC, and `cfg_len` counts bits. When the count runs out mid-byte, the leftover bits are written as one byte. The first leftover bit goes at bit 7 and the unused low bits are 0.
- R7: If `rx_full` is high when a byte is complete, that byte is not written, `st_fifoerr` is set and the block goes idle.
- R8: A sent block drives, in this order: a start bit 0, the data bytes MSB first, the CRC16 of the data MSB first, and an end bit 1. `dat_oe` is high for exactly those bits.
- R9: After a sent block, `dat_oe` is low. The block takes the 3 bits after the card's start bit as a status token. Token 010 is accepted, and the block waits until DAT is high again. Any other token sets `st_crcfail` and sends the block idle.
- R10: If the transmit FIFO is empty when the next byte is needed, `st_fifoerr` is set, `dat_oe` drops and the block goes idle.
- R11: When the remaining data count is zero in either wait state, the block goes idle and sets `st_dataend`.
- R12: In idle with the block enabled, `rw_req`=1 together with `sdio_mode`=1 makes the block drive DAT low (`dat_oe`=1, `dat_out`=0) until `rw_req` falls. With `sdio_mode`=0, `rw_req` has no effect.
- R13: A control write with `cfg_en`=0 sends the block idle from any state at the next clock. `dat_oe` drops and the current transfer produces no further FIFO traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable (1 starts a transfer, 0 shuts down) |
| cfg_dir | input | 1 | 1 = card to host, 0 = host to card |
| cfg_stream | input | 1 | 1 = stream framing, 0 = block framing |
| cfg_blklen | input | BLK_W | Block length in bytes |
| cfg_len | input | LEN_W | Total transfer length in bits |
| cfg_timeout | input | TO_W | Timeout reload value in card clocks |
| rw_req | input | 1 | SDIO read-wait request |
| sdio_mode | input | 1 | SDIO operation enabled |
| rx_wdata | output | 8 | Received byte |
| rx_wr | output | 1 | Receive FIFO write strobe |
| rx_full | input | 1 | Receive FIFO full |
| tx_rdata | input | 8 | Head byte of the transmit FIFO |
| tx_rd | output | 1 | Transmit FIFO pop strobe |
| tx_empty | input | 1 | Transmit FIFO empty |
| dat_in | input | 1 | DAT line as sampled |
| dat_out | output | 1 | DAT value driven when enabled |
| dat_oe | output | 1 | DAT output enable (0 = high impedance) |
| st_timeout | output | 1 | Sticky timeout flag |
| st_crcfail | output | 1 | Sticky CRC / status-token failure flag |
| st_fifoerr | output | 1 | Sticky FIFO overflow/underflow flag |
| st_dataend | output | 1 | Sticky data-end flag |

## Verification
The bench targets these cases:
- A one-bit-corrupted CRC trailer. A checker that compared too few bits, or that kept going after a mismatch, would set no failure flag or would keep writing bytes.
- A 12-bit stream, which ends partway through a byte. A design that dropped the leftover bits or packed them at the wrong end would deliver a wrong or missing second byte.
- Overflow and underflow. Writing into a full FIFO, or running on from an empty one, shows up as stray writes or as a line still being driven after the error.
- The timeout, sampled both before and after its expected expiry. This catches a counter that is off by one or that never reloads.
- Status tokens 010 and 101. These separate a correct token decode from one that accepts anything.
- Read-wait with SDIO mode both off and on, and a shutdown in the middle of a send. A design that ignored either gate would drive DAT when it must not.

// File: rtl/sd_dp_pkg.sv
package sd_dp_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_WAIT_R, S_RECV, S_WAIT_S, S_SEND, S_BUSY, S_RDWAIT
    } dp_state_e;

    // sub-step inside RECV / SEND / BUSY
    typedef enum logic [1:0] {PH_A, PH_B, PH_C, PH_D} phase_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/sd_dp_crc16.sv
module sd_dp_crc16 #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb    = crc_q[W-1] ^ din;
        crc_d = crc_q;
        if (clr)        crc_d = '0;
        else if (shift) crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R8: feeding the register its own MSB empties it one bit per clock (serial output)
    p_shout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr && (din == crc_q[W-1])) |=> (crc_q == ($past(crc_q) << 1)));
endmodule

// File: rtl/sd_dp_tmo.sv
module sd_dp_tmo #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TO_W-1:0] load_val,
    input  logic            run,
    output logic            expired
);
    localparam logic [TO_W-1:0] ONE = 1;
    logic [TO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                      cnt_d = load_val;
        else if (run && cnt_q != '0)   cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4: while running and not reloaded, the count drops by exactly one per clock
    p_tmo_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/sd_dpath.sv
module sd_dpath
    import sd_dp_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int LEN_W = 16,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_dir,
    input  logic             cfg_stream,
    input  logic [BLK_W-1:0] cfg_blklen,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic             rw_req,
    input  logic             sdio_mode,
    output logic [7:0]       rx_wdata,
    output logic             rx_wr,
    input  logic             rx_full,
    input  logic [7:0]       tx_rdata,
    output logic             tx_rd,
    input  logic             tx_empty,
    input  logic             dat_in,
    output logic             dat_out,
    output logic             dat_oe,
    output logic             st_timeout,
    output logic             st_crcfail,
    output logic             st_fifoerr,
    output logic             st_dataend
);
    localparam int              CRC_W  = 16;
    localparam int              CCNT_W = $clog2(CRC_W) + 1;
    localparam logic [LEN_W-1:0]  L_ONE  = 1;
    localparam logic [BLK_W-1:0]  B_ONE  = 1;
    localparam logic [CCNT_W-1:0] C_ONE  = 1;
    localparam logic [CCNT_W-1:0] C_CRC  = CCNT_W'(CRC_W - 1);
    localparam logic [CCNT_W-1:0] C_TOK  = 2;

    typedef struct packed {
        dp_state_e         st;
        phase_e            ph;
        logic              en;
        logic              strm;
        logic [BLK_W-1:0]  blen;
        logic [TO_W-1:0]   tov;
        logic [LEN_W-1:0]  dcnt;
        logic [BLK_W-1:0]  bcnt;
        logic [2:0]        bitc;
        logic [CCNT_W-1:0] ccnt;
        logic [7:0]        sh;
        logic [1:0]        tok;
        logic              rxw;
        logic [7:0]        rxd;
        logic              f_to, f_crc, f_fifo, f_end;
    } regs_t;

    regs_t d, q;
    logic [CRC_W-1:0] crc;
    logic crc_clr, crc_shift, crc_din, tmo_ld, tmo_exp;
    logic last_bit;
    logic [7:0] rx_byte;

    sd_dp_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .shift(crc_shift),
        .din(crc_din), .crc(crc)
    );

    sd_dp_tmo #(.TO_W(TO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load(tmo_ld), .load_val(d.tov),
        .run(q.st == S_WAIT_R || q.st == S_BUSY), .expired(tmo_exp)
    );

    always_comb begin
        d         = q;
        d.rxw     = 1'b0;
        tx_rd     = 1'b0;
        crc_clr   = 1'b0;
        crc_shift = 1'b0;
        crc_din   = dat_in;
        last_bit  = q.strm && (q.dcnt == L_ONE);
        rx_byte   = {q.sh[6:0], dat_in};
        case (q.st)
            S_IDLE:   if (q.en && rw_req && sdio_mode) d.st = S_RDWAIT;
            S_RDWAIT: if (!rw_req) d.st = S_IDLE;
            S_WAIT_R: begin
                if (q.dcnt == '0) begin
                    d.st = S_IDLE; d.f_end = 1'b1;
                end else if (!dat_in) begin
                    d.st = S_RECV; d.ph = PH_A; d.bcnt = q.blen; d.bitc = '0; crc_clr = 1'b1;
                end else if (tmo_exp) begin
                    d.st = S_IDLE; d.f_to = 1'b1;
                end
            end
            S_RECV: begin
                case (q.ph)
                    PH_A: begin
                        crc_shift = 1'b1;
                        d.sh      = rx_byte;
                        d.dcnt    = q.dcnt - L_ONE;
                        d.bitc    = q.bitc + 3'd1;
                        if (q.bitc == 3'd7 || last_bit) begin
                            if (rx_full) begin
                                d.st = S_IDLE; d.f_fifo = 1'b1;
                            end else begin
                                d.rxw  = 1'b1;
                                d.rxd  = rx_byte << (3'd7 - q.bitc);
                                d.bitc = '0;
                                d.bcnt = q.bcnt - B_ONE;
                                if (last_bit) d.st = S_WAIT_R;
                                else if (!q.strm && q.bcnt == B_ONE) begin
                                    d.ph = PH_B; d.ccnt = '0;
                                end
                            end
                        end
                    end
                    PH_B: begin
                        crc_shift = 1'b1;
                        d.ccnt    = q.ccnt + C_ONE;
                        if (q.ccnt == C_CRC) d.ph = PH_C;
                    end
                    default: begin
                        if (crc == '0) d.st = S_WAIT_R;
                        else begin d.st = S_IDLE; d.f_crc = 1'b1; end
                    end
                endcase
            end
            S_WAIT_S: begin
                if (q.dcnt == '0) begin
                    d.st = S_IDLE; d.f_end = 1'b1;
                end else if (!tx_empty) begin
                    d.st = S_SEND; d.ph = PH_A; d.bcnt = q.blen; d.bitc = '0; crc_clr = 1'b1;
                end
            end
            S_SEND: begin
                case (q.ph)
                    PH_A: begin
                        if (tx_empty) begin
                            d.st = S_IDLE; d.f_fifo = 1'b1;
                        end else begin
                            tx_rd = 1'b1; d.sh = tx_rdata; d.ph = PH_B;
                        end
                    end
                    PH_B: begin
                        crc_shift = 1'b1;
                        crc_din   = q.sh[7];
                        d.sh      = q.sh << 1;
                        d.dcnt    = q.dcnt - L_ONE;
                        d.bitc    = q.bitc + 3'd1;
                        if (last_bit) d.st = S_WAIT_S;
                        else if (q.bitc == 3'd7) begin
                            d.bcnt = q.bcnt - B_ONE;
                            if (!q.strm && q.bcnt == B_ONE) begin
                                d.ph = PH_C; d.ccnt = '0;
                            end else if (tx_empty) begin
                                d.st = S_IDLE; d.f_fifo = 1'b1;
                            end else begin
                                tx_rd = 1'b1; d.sh = tx_rdata;
                            end
                        end
                    end
                    PH_C: begin
                        crc_shift = 1'b1;
                        crc_din   = crc[CRC_W-1];
                        d.ccnt    = q.ccnt + C_ONE;
                        if (q.ccnt == C_CRC) d.ph = PH_D;
                    end
                    default: begin
                        d.st = S_BUSY; d.ph = PH_A;
                    end
                endcase
            end
            S_BUSY: begin
                case (q.ph)
                    PH_A: begin
                        if (!dat_in) begin
                            d.ph = PH_B; d.ccnt = '0;
                        end else if (tmo_exp) begin
                            d.st = S_IDLE; d.f_to = 1'b1;
                        end
                    end
                    PH_B: begin
                        d.tok  = {q.tok[0], dat_in};
                        d.ccnt = q.ccnt + C_ONE;
                        if (q.ccnt == C_TOK) begin
                            if ({q.tok, dat_in} != 3'b010) begin
                                d.st = S_IDLE; d.f_crc = 1'b1;
                            end else d.ph = PH_C;
                        end
                    end
                    PH_C: d.ph = PH_D;
                    default: begin
                        if (dat_in) d.st = S_WAIT_S;
                        else if (tmo_exp) begin
                            d.st = S_IDLE; d.f_to = 1'b1;
                        end
                    end
                endcase
            end
            default: d.st = S_IDLE;
        endcase

        if (cfg_wr) begin
            d.rxw = 1'b0;
            tx_rd = 1'b0;
            d.en  = cfg_en;
            if (cfg_en) begin
                d.st   = cfg_dir ? S_WAIT_R : S_WAIT_S;
                d.strm = cfg_stream;
                d.blen = cfg_blklen;
                d.tov  = cfg_timeout;
                d.dcnt = cfg_len;
                {d.f_to, d.f_crc, d.f_fifo, d.f_end} = '0;
            end else begin
                d.st = S_IDLE;
            end
        end
        tmo_ld = (d.st == S_WAIT_R || d.st == S_BUSY) && (d.st != q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
            q.ph <= PH_A;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dat_oe  = (q.st == S_SEND) || (q.st == S_RDWAIT);
        dat_out = 1'b1;
        if (q.st == S_RDWAIT) dat_out = 1'b0;
        else if (q.st == S_SEND) begin
            case (q.ph)
                PH_A:    dat_out = 1'b0;
                PH_B:    dat_out = q.sh[7];
                PH_C:    dat_out = crc[CRC_W-1];
                default: dat_out = 1'b1;
            endcase
        end
    end

    assign rx_wr      = q.rxw;
    assign rx_wdata   = q.rxd;
    assign st_timeout = q.f_to;
    assign st_crcfail = q.f_crc;
    assign st_fifoerr = q.f_fifo;
    assign st_dataend = q.f_end;

    // R7: no byte reaches the receive FIFO if it was full when the byte completed
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> !$past(rx_full));
    // R10: the transmit FIFO is never popped while empty
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd |-> !tx_empty);
    // R4: a timeout only arises from one of the two waiting states
    p_tmo_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_timeout) |-> ($past(q.st) == S_WAIT_R || $past(q.st) == S_BUSY));
    // R11: data end is only flagged with the count exhausted
    p_dataend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_dataend) |-> ($past(q.dcnt) == '0));
    // R13: shutdown releases the line and stops FIFO traffic on the next clock
    p_shutdown_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_en) |=> (!dat_oe && !rx_wr && !tx_rd));
    // R12: the read-wait drive is only held while the request was present
    p_rdwait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RDWAIT) |-> $past(rw_req && sdio_mode || q.st == S_RDWAIT));
endmodule

// File: tb/sim_sd_dpath.sv
`timescale 1ns/1ps
module sim_sd_dpath;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_dir = 1'b0, cfg_stream = 1'b0;
    logic [9:0]  cfg_blklen = '0;
    logic [15:0] cfg_len = '0;
    logic [15:0] cfg_timeout = '0;
    logic rw_req = 1'b0, sdio_mode = 1'b0;
    logic [7:0] rx_wdata;
    logic rx_wr;
    logic rx_full = 1'b0;
    logic [7:0] tx_rdata;
    logic tx_rd, tx_empty;
    logic dat_in = 1'b1;
    logic dat_out, dat_oe;
    logic st_timeout, st_crcfail, st_fifoerr, st_dataend;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] rx_mem [0:63];
    int rx_n = 0;
    logic [7:0] tx_mem [0:63];
    int tx_ptr = 0, tx_n = 0;

    always #2.5 clk = ~clk;

    sd_dpath u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
        .cfg_stream(cfg_stream), .cfg_blklen(cfg_blklen), .cfg_len(cfg_len),
        .cfg_timeout(cfg_timeout), .rw_req(rw_req), .sdio_mode(sdio_mode),
        .rx_wdata(rx_wdata), .rx_wr(rx_wr), .rx_full(rx_full), .tx_rdata(tx_rdata),
        .tx_rd(tx_rd), .tx_empty(tx_empty), .dat_in(dat_in), .dat_out(dat_out),
        .dat_oe(dat_oe), .st_timeout(st_timeout), .st_crcfail(st_crcfail),
        .st_fifoerr(st_fifoerr), .st_dataend(st_dataend)
    );

    // host-side FIFO models
    assign tx_empty = (tx_ptr >= tx_n);
    assign tx_rdata = tx_mem[tx_ptr[5:0]];
    always @(posedge clk) begin
        if (tx_rd) tx_ptr <= tx_ptr + 1;
        if (rx_wr) begin
            rx_mem[rx_n[5:0]] <= rx_wdata;
            rx_n <= rx_n + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        crc_step = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic [15:0] crc_of(input logic [15:0] bits);
        logic [15:0] c = '0;
        for (int i = 15; i >= 0; i--) c = crc_step(c, bits[i]);
        return c;
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drv(input logic b);
        @(negedge clk); dat_in = b;
    endtask

    task automatic cfg(input logic en, input logic dir, input logic strm,
                       input int blk, input int len, input int tmo);
        @(negedge clk);
        cfg_en = en; cfg_dir = dir; cfg_stream = strm;
        cfg_blklen = 10'(blk); cfg_len = 16'(len); cfg_timeout = 16'(tmo);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic tx_load(input int k, input logic [7:0] b0, input logic [7:0] b1);
        tx_mem[tx_ptr[5:0]] = b0;
        tx_mem[6'(tx_ptr + 1)] = b1;
        tx_n = tx_ptr + k;
    endtask

    // card sends: idle, start, 16 data bits, CRC (optionally corrupted), end bit
    task automatic card_block(input logic [15:0] data, input bit bad);
        logic [15:0] c = crc_of(data);
        if (bad) c[0] = ~c[0];
        drv(1); drv(1); drv(0);
        for (int i = 15; i >= 0; i--) drv(data[i]);
        for (int i = 15; i >= 0; i--) drv(c[i]);
        drv(1); drv(1); drv(1); drv(1);
    endtask

    task automatic capture_tx(output logic [15:0] data, output logic [15:0] crc,
                              output logic endb, output logic startb);
        int w = 0;
        @(negedge clk);
        while (!dat_oe && w < 20) begin @(negedge clk); w++; end
        startb = dat_out;
        data = '0; crc = '0;
        for (int i = 0; i < 16; i++) begin @(negedge clk); data = {data[14:0], dat_out}; end
        for (int i = 0; i < 16; i++) begin @(negedge clk); crc = {crc[14:0], dat_out}; end
        @(negedge clk); endb = dat_out;
    endtask

    task automatic card_token(input logic [2:0] tok, output logic oe_busy);
        dat_in = 1'b1;
        @(negedge clk); oe_busy = dat_oe; dat_in = 1'b0;
        for (int i = 2; i >= 0; i--) drv(tok[i]);
        drv(1); drv(0); drv(0); drv(0); drv(1);
        cyc(4);
    endtask

    task automatic t_reset;
        cyc(2);
        check("R1 dat_oe in reset", dat_oe, 0);
        rst_n = 1'b1;
        cyc(3);
        check("R1 dat_oe idle", dat_oe, 0);
        check("R1 rx_wr idle", rx_wr, 0);
        check("R1 flags clear", {st_timeout, st_crcfail, st_fifoerr, st_dataend}, 0);
    endtask

    task automatic t_block_read;
        int base = rx_n;
        cfg(1, 1, 0, 2, 32, 100);
        card_block(16'h5AC3, 0);
        card_block(16'h0F81, 0);
        cyc(4);
        check("R3 byte count", rx_n - base, 4);
        check("R3 byte0", rx_mem[base[5:0]], 8'h5A);
        check("R3 byte1", rx_mem[6'(base + 1)], 8'hC3);
        check("R3 byte2", rx_mem[6'(base + 2)], 8'h0F);
        check("R3 byte3", rx_mem[6'(base + 3)], 8'h81);
        check("R5 good crc no fail", st_crcfail, 0);
        check("R11 data end after read", st_dataend, 1);
    endtask

    task automatic t_bad_crc;
        int base = rx_n;
        cfg(1, 1, 0, 2, 32, 100);
        check("R2 flags cleared by enable", st_dataend, 0);
        card_block(16'h1122, 1);
        cyc(2);
        check("R5 crc fail flag", st_crcfail, 1);
        card_block(16'h3344, 0);
        cyc(2);
        check("R5 no writes after fail", rx_n - base, 2);
        check("R5 no data end", st_dataend, 0);
    endtask

    task automatic t_stream;
        int base = rx_n;
        logic [11:0] bits = 12'hA5C;
        cfg(1, 1, 1, 2, 12, 100);
        drv(1); drv(0);
        for (int i = 11; i >= 0; i--) drv(bits[i]);
        drv(1); cyc(4);
        check("R6 stream byte count", rx_n - base, 2);
        check("R6 full byte", rx_mem[base[5:0]], 8'hA5);
        check("R6 flushed partial", rx_mem[6'(base + 1)], 8'hC0);
        check("R6 stream data end", st_dataend, 1);
        check("R6 no crc in stream", st_crcfail, 0);
    endtask

    task automatic t_overflow;
        int base = rx_n;
        rx_full = 1'b1;
        cfg(1, 1, 0, 2, 16, 100);
        card_block(16'h7E7E, 0);
        check("R7 fifo error", st_fifoerr, 1);
        check("R7 no write while full", rx_n - base, 0);
        rx_full = 1'b0;
    endtask

    task automatic t_timeout;
        dat_in = 1'b1;
        cfg(1, 1, 0, 2, 16, 10);
        cyc(7);
        check("R4 not yet timed out", st_timeout, 0);
        cyc(8);
        check("R4 timeout flag", st_timeout, 1);
        check("R4 line released", dat_oe, 0);
    endtask

    task automatic t_readwait;
        cfg(1, 1, 0, 2, 0, 50);
        cyc(2);
        check("R11 zero length ends at once", st_dataend, 1);
        sdio_mode = 1'b0; rw_req = 1'b1;
        cyc(3);
        check("R12 ignored without sdio mode", dat_oe, 0);
        sdio_mode = 1'b1;
        cyc(2);
        check("R12 read wait drives", dat_oe, 1);
        check("R12 read wait low", dat_out, 0);
        rw_req = 1'b0;
        cyc(2);
        check("R12 read wait ends", dat_oe, 0);
        sdio_mode = 1'b0;
    endtask

    task automatic t_write(input logic [2:0] tok, input bit good);
        logic [15:0] data, crc;
        logic endb, startb, oe_b;
        tx_load(2, 8'h3C, 8'hA1);
        cfg(1, 0, 0, 2, 16, 200);
        capture_tx(data, crc, endb, startb);
        card_token(tok, oe_b);
        if (good) begin
            check("R8 start bit", startb, 0);
            check("R8 data bits", data, 16'h3CA1);
            check("R8 crc bits", crc, crc_of(16'h3CA1));
            check("R8 end bit", endb, 1);
            check("R9 released in busy", oe_b, 0);
            check("R9 token accepted", st_crcfail, 0);
            check("R11 write data end", st_dataend, 1);
        end else begin
            check("R9 bad token fail", st_crcfail, 1);
            check("R9 no data end", st_dataend, 0);
        end
    endtask

    task automatic t_underflow;
        tx_load(1, 8'hF0, 8'h00);
        cfg(1, 0, 0, 2, 16, 200);
        cyc(30);
        check("R10 underflow flag", st_fifoerr, 1);
        check("R10 line released", dat_oe, 0);
        check("R10 no data end", st_dataend, 0);
    endtask

    task automatic t_disable;
        int hi = 0;
        int w = 0;
        tx_load(2, 8'h55, 8'h66);
        cfg(1, 0, 0, 2, 16, 200);
        while (!dat_oe && w < 20) begin @(negedge clk); w++; end
        check("R2 write starts", dat_oe, 1);
        cyc(3);
        cfg(0, 0, 0, 2, 16, 200);
        for (int i = 0; i < 40; i++) begin
            if (dat_oe) hi++;
            @(negedge clk);
        end
        check("R13 line off after disable", hi, 0);
        check("R13 no data end", st_dataend, 0);
    endtask

    initial begin
        t_reset();
        t_block_read();
        t_bad_crc();
        t_stream();
        t_overflow();
        t_timeout();
        t_readwait();
        t_write(3'b010, 1);
        t_write(3'b101, 0);
        t_underflow();
        t_disable();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule